// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the slave side of a serial NOR flash command interface. A byte-level shifter in front of it hands over one received byte per strobe while chip select is low. The sequencer returns one response byte per strobe. The first byte after a chip-select falling edge is an opcode. Depending on that opcode, the block answers at once, collects a fixed number of header bytes, or enters a streaming phase. Address and dummy bytes are header bytes.

In the streaming phases the block does one of three things. It returns array bytes from a read port. It emits one program request per received byte. It emits a single erase request. It also keeps the write-enable latch and answers the status query and the identification query. The identification word and its extension are strap inputs. The manufacturer byte of that word picks how many header bytes the two multi-lane I/O read opcodes take. The lanes themselves are not modelled: those commands arrive here as plain byte streams.

Top module: `spi_flash_seq`

## Requirements
- R1: A falling edge of `cs_n` returns the sequencer to idle and clears its byte counters, even in the middle of a command. A strobe seen while `cs_n` is high, or in the cycle of the falling edge, is ignored: no response pulse, no request, no state change.
- R2: Opcodes 0x02, 0x03, 0x20, 0x32, 0x52, 0xA2 and 0xD8 collect 3 header bytes. Opcodes 0x0B, 0x3B and 0x6B collect 4 header bytes.
- R3: The manufacturer byte is `id_word[23:16]`. When it is 0xEF or 0x01, opcode 0xBB collects 4 header bytes and 0xEB collects 6. For any other value, 0xBB collects 5 and 0xEB collects 8.
- R4: The first three header bytes form the 24-bit start address, most significant byte first. Header bytes after the third are discarded.
- R5: Read opcodes (0x03, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB) enter the read phase once the header is complete. There, each strobe returns `rd_data` for the current `rd_addr`, and the address then advances. It wraps from ARRAY_BYTES-1 to 0.
- R6: Program opcodes (0x02, 0x32, 0xA2) enter the program phase once the header is complete. There, each received byte raises `prog_req` for one cycle, with `prog_addr` set to the current address and `prog_data` to the byte. The address then increments.
- R7: Sector-type erase opcodes return to idle once the header is complete. If the write-enable latch is set, they pulse `erase_req` with the collected address. `erase_kind` is 2'b00 for 0x20, 2'b01 for 0x52 and 2'b10 for 0xD8. If the latch is clear, no request is made.
- R8: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The latch is clear after reset. Opcode 0xC7 pulses `erase_req` with `erase_kind` 2'b11 and address 0, but only when the latch is set.
- R9: After opcode 0x05, the next strobe returns the status byte and the sequencer goes back to idle. The status byte carries the write-enable latch in bit 1 and zero in all other bits.
- R10: After opcode 0x9F, the following strobes return `id_word[23:16]`, `id_word[15:8]` and `id_word[7:0]`. When `ext_id` is nonzero, they then return `ext_id[15:8]` and `ext_id[7:0]`. The sequencer then goes back to idle.
- R11: Opcode 0x01 is taken only while the write-enable latch is set. It collects one byte and then clears the latch. While the latch is clear, 0x01 is ignored and the next byte is decoded as a fresh opcode.
- R12: Opcode 0x00 and unknown opcodes leave the sequencer idle. The response byte is 0x00 for opcode, header and program strobes.
- R13: Every accepted strobe produces exactly one `resp_valid` pulse in the next cycle, and `prog_req` and `erase_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its falling edge restarts command parsing |
| xfer_valid | input | 1 | One-cycle strobe: a received byte is present |
| xfer_byte | input | 8 | Received byte |
| id_word | input | 24 | Identification strap; bits 23:16 are the manufacturer byte |
| ext_id | input | 16 | Extended identification strap; zero means absent |
| rd_data | input | 8 | Array byte at `rd_addr`, combinational from the storage engine |
| rd_addr | output | 24 | Current array address |
| resp_byte | output | 8 | Response byte for the previous accepted strobe |
| resp_valid | output | 1 | Pulses one cycle after each accepted strobe |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 24 | Program address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | Erase size code (see R7, R8) |
| erase_addr | output | 24 | Erase address |

## Verification
Every result of this block is registered at the clock edge that accepts the strobe. The response byte, `resp_valid`, `prog_req` and `erase_req` are therefore due exactly one cycle after `xfer_valid`. The bench drives each strobe for one cycle from a falling clock edge and samples all outputs at the next falling edge, halfway after the accepting edge. A header-length check counts strobes: the last header strobe must still answer 0x00, and the very next strobe must already return array data. Latch effects, such as a 0x01 or erase opcode being ignored, are read back through the status query on the following command.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

  localparam int unsigned AW = 24;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_PROG    = 3'd2,
    ST_READ    = 3'd3,
    ST_RESP    = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_READ  = 3'd1,
    CL_PROG  = 3'd2,
    CL_ERASE = 3'd3,
    CL_STWR  = 3'd4
  } op_class_e;

  typedef struct packed {
    op_class_e  cls;
    logic [3:0] hdr;
    logic [1:0] ekind;
    logic       latch_on;
    logic       latch_off;
    logic       stat_q;
    logic       id_q;
    logic       whole_erase;
  } op_info_t;

  // Header length of the multi-lane I/O reads depends on the vendor byte.
  function automatic logic short_io_vendor(input logic [7:0] mfr);
    return (mfr == 8'hEF) || (mfr == 8'h01);
  endfunction

  function automatic op_info_t decode_op(input logic [7:0] op, input logic [7:0] mfr);
    op_info_t i;
    i = '0;
    i.cls = CL_NONE;
    case (op)
      8'h03:               begin i.cls = CL_READ;  i.hdr = 4'd3; end
      8'h0B, 8'h3B, 8'h6B: begin i.cls = CL_READ;  i.hdr = 4'd4; end
      8'hBB: begin i.cls = CL_READ; i.hdr = short_io_vendor(mfr) ? 4'd4 : 4'd5; end
      8'hEB: begin i.cls = CL_READ; i.hdr = short_io_vendor(mfr) ? 4'd6 : 4'd8; end
      8'h02, 8'h32, 8'hA2: begin i.cls = CL_PROG;  i.hdr = 4'd3; end
      8'h20: begin i.cls = CL_ERASE; i.hdr = 4'd3; i.ekind = 2'b00; end
      8'h52: begin i.cls = CL_ERASE; i.hdr = 4'd3; i.ekind = 2'b01; end
      8'hD8: begin i.cls = CL_ERASE; i.hdr = 4'd3; i.ekind = 2'b10; end
      8'h01: begin i.cls = CL_STWR;  i.hdr = 4'd1; end
      8'h06: i.latch_on    = 1'b1;
      8'h04: i.latch_off   = 1'b1;
      8'h05: i.stat_q      = 1'b1;
      8'h9F: i.id_q        = 1'b1;
      8'hC7: i.whole_erase = 1'b1;
      default: ;
    endcase
    return i;
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic wrap,
                                              input logic [AW-1:0] last);
    if (wrap && (a == last)) return '0;
    return a + 1'b1;
  endfunction

endpackage

// File: rtl/sfs_opdec.sv
module sfs_opdec
  import spi_flash_seq_pkg::*;
(
  input  logic [7:0] op,
  input  logic [7:0] mfr,
  output op_info_t   info
);

  always_comb begin
    info = decode_op(op, mfr);
  end

  // Header lengths are limited to the set the command table can produce.
  always_comb begin
    assert_hdr_legal_R2: assert (info.hdr == 4'd0 || info.hdr == 4'd1 ||
                                 info.hdr == 4'd3 || info.hdr == 4'd4 ||
                                 info.hdr == 4'd5 || info.hdr == 4'd6 ||
                                 info.hdr == 4'd8)
      else $error("illegal header length");
  end

endmodule

// File: rtl/sfs_wel.sv
module sfs_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic wel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wel <= 1'b0;
    else if (set) wel <= 1'b1;
    else if (clr) wel <= 1'b0;
  end

  assert_wel_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> wel);
  assert_wel_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !wel);

endmodule

// File: rtl/sfs_addr_ctr.sv
module sfs_addr_ctr
  import spi_flash_seq_pkg::*;
#(
  parameter logic [AW-1:0] LAST = 24'hFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [7:0]    shift_byte,
  input  logic          inc_en,
  input  logic          wrap_en,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr_shifted
);

  assign addr_shifted = {addr[AW-9:0], shift_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (shift_en)  addr <= addr_shifted;
    else if (inc_en)    addr <= step_addr(addr, wrap_en, LAST);
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !shift_en && wrap_en && addr == LAST) |=> (addr == '0));
  assert_prog_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !shift_en && !wrap_en) |=> (addr == $past(addr) + 24'd1));

endmodule

// File: rtl/sfs_resp_buf.sv
module sfs_resp_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load_stat,
  input  logic        load_id,
  input  logic        wel,
  input  logic [23:0] id_word,
  input  logic [15:0] ext_id,
  input  logic        adv,
  output logic [7:0]  byte_o,
  output logic        last_o
);

  localparam int unsigned DEPTH = 5;

  logic [7:0] bytes_q [DEPTH];
  logic [2:0] len_q;
  logic [2:0] idx_q;
  logic [7:0] id_bytes [DEPTH];

  assign id_bytes[0] = id_word[23:16];
  assign id_bytes[1] = id_word[15:8];
  assign id_bytes[2] = id_word[7:0];
  assign id_bytes[3] = ext_id[15:8];
  assign id_bytes[4] = ext_id[7:0];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     bytes_q[g] <= 8'h00;
        else if (load_id)               bytes_q[g] <= id_bytes[g];
        else if (load_stat && g == 0)   bytes_q[g] <= {6'b0, wel, 1'b0};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 3'd0;
      idx_q <= 3'd0;
    end else if (load_id) begin
      len_q <= (ext_id != 16'h0000) ? 3'd5 : 3'd3;
      idx_q <= 3'd0;
    end else if (load_stat) begin
      len_q <= 3'd1;
      idx_q <= 3'd0;
    end else if (clr) begin
      idx_q <= 3'd0;
    end else if (adv) begin
      idx_q <= last_o ? 3'd0 : idx_q + 3'd1;
    end
  end

  assign byte_o = (idx_q < 3'(DEPTH)) ? bytes_q[idx_q] : 8'h00;
  assign last_o = (idx_q + 3'd1) == len_q;

  assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != 3'd0) |-> (idx_q < len_q));

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_seq_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 1 << 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          xfer_valid,
  input  logic [7:0]    xfer_byte,
  input  logic [23:0]   id_word,
  input  logic [15:0]   ext_id,
  input  logic [7:0]    rd_data,
  output logic [23:0]   rd_addr,
  output logic [7:0]    resp_byte,
  output logic          resp_valid,
  output logic          prog_req,
  output logic [23:0]   prog_addr,
  output logic [7:0]    prog_data,
  output logic          erase_req,
  output logic [1:0]    erase_kind,
  output logic [23:0]   erase_addr
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(ARRAY_BYTES - 1);
  localparam int unsigned   ADDR_BYTES = AW / 8;

  // Named internal events
  logic cs_prev_q;
  logic cs_fall;
  logic take;

  seq_state_e state_q, state_d;
  op_class_e  cls_q, cls_d;
  logic [3:0] need_q, need_d;
  logic [3:0] cnt_q, cnt_d;
  logic [1:0] ekind_q, ekind_d;

  op_info_t   info;
  logic       wel;
  logic       wel_set, wel_clr;
  logic       shift_en, inc_en, wrap_en;
  logic [AW-1:0] addr, addr_shifted;
  logic       buf_stat, buf_id, buf_adv;
  logic [7:0] buf_byte;
  logic       buf_last;
  logic       hdr_done;

  logic [7:0]    resp_d;
  logic          prog_d, erase_d;
  logic [1:0]    ekind_out_d;
  logic [AW-1:0] eaddr_d;

  assign cs_fall  = !cs_n && cs_prev_q;
  assign take     = xfer_valid && !cs_n && !cs_fall;
  assign hdr_done = (cnt_q + 4'd1) == need_q;

  sfs_opdec u_dec (
    .op   (xfer_byte),
    .mfr  (id_word[23:16]),
    .info (info)
  );

  sfs_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wel_set),
    .clr   (wel_clr),
    .wel   (wel)
  );

  sfs_addr_ctr #(.LAST(LAST_ADDR)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .shift_byte   (xfer_byte),
    .inc_en       (inc_en),
    .wrap_en      (wrap_en),
    .addr         (addr),
    .addr_shifted (addr_shifted)
  );

  sfs_resp_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_fall),
    .load_stat (buf_stat),
    .load_id   (buf_id),
    .wel       (wel),
    .id_word   (id_word),
    .ext_id    (ext_id),
    .adv       (buf_adv),
    .byte_o    (buf_byte),
    .last_o    (buf_last)
  );

  always_comb begin
    state_d     = state_q;
    cls_d       = cls_q;
    need_d      = need_q;
    cnt_d       = cnt_q;
    ekind_d     = ekind_q;
    wel_set     = 1'b0;
    wel_clr     = 1'b0;
    shift_en    = 1'b0;
    inc_en      = 1'b0;
    wrap_en     = 1'b0;
    buf_stat    = 1'b0;
    buf_id      = 1'b0;
    buf_adv     = 1'b0;
    resp_d      = 8'h00;
    prog_d      = 1'b0;
    erase_d     = 1'b0;
    ekind_out_d = erase_kind;
    eaddr_d     = erase_addr;

    if (cs_fall) begin
      state_d = ST_IDLE;
      cnt_d   = 4'd0;
      need_d  = 4'd0;
    end else if (take) begin
      unique case (state_q)
        ST_IDLE: begin
          if (info.hdr != 4'd0 && (info.cls != CL_STWR || wel)) begin
            state_d = ST_COLLECT;
            cls_d   = info.cls;
            need_d  = info.hdr;
            cnt_d   = 4'd0;
            ekind_d = info.ekind;
          end
          if (info.latch_on)  wel_set = 1'b1;
          if (info.latch_off) wel_clr = 1'b1;
          if (info.stat_q) begin
            buf_stat = 1'b1;
            state_d  = ST_RESP;
          end
          if (info.id_q) begin
            buf_id  = 1'b1;
            state_d = ST_RESP;
          end
          if (info.whole_erase) begin
            erase_d     = wel;
            ekind_out_d = 2'b11;
            eaddr_d     = '0;
          end
        end
        ST_COLLECT: begin
          shift_en = cnt_q < 4'(ADDR_BYTES);
          cnt_d    = cnt_q + 4'd1;
          if (hdr_done) begin
            cnt_d   = 4'd0;
            state_d = ST_IDLE;
            unique case (cls_q)
              CL_READ:  state_d = ST_READ;
              CL_PROG:  state_d = ST_PROG;
              CL_ERASE: begin
                erase_d     = wel;
                ekind_out_d = ekind_q;
                eaddr_d     = addr_shifted;
              end
              CL_STWR:  wel_clr = 1'b1;
              default:  ;
            endcase
          end
        end
        ST_PROG: begin
          prog_d = 1'b1;
          inc_en = 1'b1;
        end
        ST_READ: begin
          resp_d  = rd_data;
          inc_en  = 1'b1;
          wrap_en = 1'b1;
        end
        ST_RESP: begin
          resp_d  = buf_byte;
          buf_adv = 1'b1;
          if (buf_last) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      state_q    <= ST_IDLE;
      cls_q      <= CL_NONE;
      need_q     <= 4'd0;
      cnt_q      <= 4'd0;
      ekind_q    <= 2'b00;
      resp_byte  <= 8'h00;
      resp_valid <= 1'b0;
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= 8'h00;
      erase_req  <= 1'b0;
      erase_kind <= 2'b00;
      erase_addr <= '0;
    end else begin
      cs_prev_q  <= cs_n;
      state_q    <= state_d;
      cls_q      <= cls_d;
      need_q     <= need_d;
      cnt_q      <= cnt_d;
      ekind_q    <= ekind_d;
      resp_valid <= take;
      if (take) resp_byte <= resp_d;
      prog_req   <= prog_d;
      if (prog_d) begin
        prog_addr <= addr;
        prog_data <= xfer_byte;
      end
      erase_req  <= erase_d;
      erase_kind <= ekind_out_d;
      erase_addr <= eaddr_d;
    end
  end

  assign rd_addr = addr;

  // Assertions
  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (state_q == ST_IDLE && cnt_q == 4'd0));
  assert_strobe_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || prog_req || erase_req) |-> $past(take));
  assert_hdr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT) |-> (cnt_q < need_q));
  assert_erase_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel));
  assert_one_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));
  assert_quiet_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(state_q) != ST_READ && $past(state_q) != ST_RESP)
      |-> (resp_byte == 8'h00));

endmodule

// File: tb/spi_flash_seq_tb.sv
`timescale 1ns/1ps
module spi_flash_seq_tb_top;

  localparam int unsigned ARRAY_BYTES = 1 << 20;
  localparam int unsigned NVEC = 21;

  // {new_cs, tx byte, expected response}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h9F, 8'h00}, {1'b0, 8'h00, 8'h20}, {1'b0, 8'h00, 8'h20},
    {1'b0, 8'h00, 8'h14}, {1'b0, 8'h05, 8'h00}, {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h03, 8'h00}, {1'b0, 8'h01, 8'h00}, {1'b0, 8'h23, 8'h00},
    {1'b0, 8'h45, 8'h00}, {1'b0, 8'h00, 8'hC2}, {1'b0, 8'h00, 8'hC1},
    {1'b1, 8'h06, 8'h00}, {1'b0, 8'h05, 8'h00}, {1'b0, 8'h00, 8'h02},
    {1'b1, 8'h0B, 8'h00}, {1'b0, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00},
    {1'b0, 8'h80, 8'h00}, {1'b0, 8'h77, 8'h00}, {1'b0, 8'h00, 8'h25}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        xfer_valid = 1'b0;
  logic [7:0]  xfer_byte = 8'h00;
  logic [23:0] id_word = 24'h202014;
  logic [15:0] ext_id = 16'h0000;
  logic [7:0]  rd_data;
  logic [23:0] rd_addr;
  logic [7:0]  resp_byte;
  logic        resp_valid, prog_req, erase_req;
  logic [23:0] prog_addr, erase_addr;
  logic [7:0]  prog_data;
  logic [1:0]  erase_kind;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  g_resp;
  logic        g_rv, g_prog, g_erase;
  logic [23:0] g_paddr, g_eaddr;
  logic [7:0]  g_pdata;
  logic [1:0]  g_ekind;

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign rd_data = memf(rd_addr);

  spi_flash_seq #(.ARRAY_BYTES(ARRAY_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_valid(xfer_valid),
    .xfer_byte(xfer_byte), .id_word(id_word), .ext_id(ext_id),
    .rd_data(rd_data), .rd_addr(rd_addr), .resp_byte(resp_byte),
    .resp_valid(resp_valid), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_kind(erase_kind),
    .erase_addr(erase_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_byte  = b;
    @(negedge clk);
    xfer_valid = 1'b0;
    g_resp = resp_byte;  g_rv = resp_valid;
    g_prog = prog_req;   g_paddr = prog_addr;  g_pdata = prog_data;
    g_erase = erase_req; g_ekind = erase_kind; g_eaddr = erase_addr;
  endtask

  task automatic new_cmd();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    new_cmd();
    xfer(8'h05);
    xfer(8'h00);
    chk(tag, g_resp, exp);
  endtask

  // Opcode, then nh header bytes (address then zeros); next strobe must read data.
  task automatic hdr_read(input string tag, input logic [7:0] op, input int nh,
                          input logic [23:0] a);
    new_cmd();
    xfer(op);
    for (int i = 0; i < nh; i++) begin
      if (i == 0)      xfer(a[23:16]);
      else if (i == 1) xfer(a[15:8]);
      else if (i == 2) xfer(a[7:0]);
      else             xfer(8'h00);
    end
    chk({tag, " last header byte"}, g_resp, 8'h00);
    xfer(8'h00);
    chk({tag, " first data"}, g_resp, memf(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R13 reset resp_valid", resp_valid, 0);
    chk("R12 reset resp_byte", resp_byte, 8'h00);
    chk("R13 reset prog_req", prog_req, 0);
    chk("R7 reset erase_req", erase_req, 0);
    rst_n = 1'b1;
    status_is("R8 latch clear after reset", 8'h00);

    // vector table: id query, status, reads with R4 address order
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][16]) new_cmd();
      xfer(VEC[v][15:8]);
      chk($sformatf("R5/R9/R10 vector %0d", v), g_resp, VEC[v][7:0]);
      chk($sformatf("R13 vector %0d resp_valid", v), g_rv, 1);
    end

    // R1: strobe with cs_n high ignored; latch currently set
    @(negedge clk); cs_n = 1'b1;
    xfer(8'h04);
    chk("R1 no response while deselected", g_rv, 0);
    status_is("R1 latch untouched by ignored strobe", 8'h02);
    // R1: chip select mid-command restarts parsing
    new_cmd(); xfer(8'h03); xfer(8'h01);
    status_is("R1 restart mid-header", 8'h02);

    // R2 / R3 header lengths
    hdr_read("R2 op 03", 8'h03, 3, 24'h000040);
    hdr_read("R2 op 3B", 8'h3B, 4, 24'h000041);
    hdr_read("R2 op 6B", 8'h6B, 4, 24'h000042);
    hdr_read("R3 BB other vendor", 8'hBB, 5, 24'h000043);
    hdr_read("R3 EB other vendor", 8'hEB, 8, 24'h000044);
    id_word = 24'hEF4017;
    hdr_read("R3 BB short vendor", 8'hBB, 4, 24'h000045);
    id_word = 24'h010219;
    hdr_read("R3 EB short vendor", 8'hEB, 6, 24'h000046);

    // R5 wrap at array end
    new_cmd(); xfer(8'h03); xfer(8'h0F); xfer(8'hFF); xfer(8'hFF);
    xfer(8'h00);
    chk("R5 last array byte", g_resp, memf(24'h0FFFFF));
    xfer(8'h00);
    chk("R5 wrapped to zero", g_resp, memf(24'h000000));

    // R6 program stream, R12 zero responses
    new_cmd(); xfer(8'h02); xfer(8'h00); xfer(8'h01); xfer(8'hFE);
    chk("R2 program header no request", g_prog, 0);
    xfer(8'hD1);
    chk("R6 first prog_req", g_prog, 1);
    chk("R6 first addr", g_paddr, 24'h0001FE);
    chk("R6 first data", g_pdata, 8'hD1);
    chk("R12 program resp zero", g_resp, 8'h00);
    xfer(8'hD2); xfer(8'hD3);
    chk("R6 third addr", g_paddr, 24'h000200);
    chk("R6 third data", g_pdata, 8'hD3);

    // R7 erase gated by latch
    new_cmd(); xfer(8'h04);
    new_cmd(); xfer(8'h20); xfer(8'h00); xfer(8'h10); xfer(8'h00);
    chk("R7 no erase with latch clear", g_erase, 0);
    new_cmd(); xfer(8'h06);
    new_cmd(); xfer(8'h52); xfer(8'h12); xfer(8'h34);
    chk("R7 no erase before third byte", g_erase, 0);
    xfer(8'h56);
    chk("R7 32K erase req", g_erase, 1);
    chk("R7 32K kind", g_ekind, 2'b01);
    chk("R7 32K addr", g_eaddr, 24'h123456);
    xfer(8'h05); xfer(8'h00);
    chk("R7 idle after erase", g_resp, 8'h02);
    new_cmd(); xfer(8'hD8); xfer(8'h0A); xfer(8'h00); xfer(8'h00);
    chk("R7 sector kind", g_ekind, 2'b10);
    chk("R7 sector addr", g_eaddr, 24'h0A0000);
    new_cmd(); xfer(8'h20); xfer(8'h00); xfer(8'h30); xfer(8'h00);
    chk("R7 4K kind", g_ekind, 2'b00);

    // R8 whole-array erase
    new_cmd(); xfer(8'hC7);
    chk("R8 chip erase req", g_erase, 1);
    chk("R8 chip erase kind", g_ekind, 2'b11);
    chk("R8 chip erase addr", g_eaddr, 24'h000000);
    new_cmd(); xfer(8'h04);
    new_cmd(); xfer(8'hC7);
    chk("R8 chip erase blocked", g_erase, 0);

    // R11 status write
    new_cmd(); xfer(8'h01); xfer(8'h9F); xfer(8'h00);
    chk("R11 ignored while latch clear", g_resp, 8'h01);
    new_cmd(); xfer(8'h06);
    new_cmd(); xfer(8'h01); xfer(8'h55);
    status_is("R11 latch cleared after write", 8'h00);

    // R10 extended id
    ext_id = 16'h4D01;
    new_cmd(); xfer(8'h9F);
    xfer(8'h00); chk("R10 ext byte0", g_resp, 8'h01);
    xfer(8'h00); chk("R10 ext byte1", g_resp, 8'h02);
    xfer(8'h00); chk("R10 ext byte2", g_resp, 8'h19);
    xfer(8'h00); chk("R10 ext byte3", g_resp, 8'h4D);
    xfer(8'h00); chk("R10 ext byte4", g_resp, 8'h01);
    xfer(8'h06); chk("R10 idle after id", g_resp, 8'h00);
    xfer(8'h05); xfer(8'h00);
    chk("R10 opcode after id decoded", g_resp, 8'h02);

    // R12 unknown and zero opcodes keep idle
    new_cmd(); xfer(8'h99);
    chk("R12 unknown resp", g_resp, 8'h00);
    xfer(8'h00); xfer(8'h05); xfer(8'h00);
    chk("R12 idle after unknown", g_resp, 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule